// File: doc/BRIEF.md
# Three-Channel LED PWM Generator

This block drives the enable inputs of red, green and blue LED drivers with pulse-width-modulated waveforms. Each channel takes a 12-bit duty value. A shared period counter runs from the system clock and steps through 4095 states. A channel is in its asserted state while the counter is below the channel's captured duty value. The electrical level of that asserted state is chosen by a polarity input, so drivers with active-high or active-low enables can both be served.

Switching is gated by a run-enable input. The block has three states. In ST_IDLE the counter rests at zero and every output sits at the idle level, which equals the polarity bit. The transition "start" (run_en high in ST_IDLE) moves the block to ST_LOAD. ST_LOAD lasts one cycle, captures all three duty inputs into shadow registers, and keeps the outputs idle. The transition "go" (run_en still high in ST_LOAD) moves it to ST_RUN. ST_RUN counts 0 to 4094 and reloads the shadows on each wrap. The transition "stop" (run_en low in ST_LOAD or ST_RUN) returns the block to ST_IDLE.

A second, free-running divider produces a one-cycle sample tick every 25087 clocks. A colour feedback loop paces its corrections on this tick. At 2.5 MHz the PWM rate is about 610 Hz and the tick rate is about 100 Hz.

Top module: `rgb_pwm_gen`

## Requirements
- R1: While rst_n is low, and right after it is released with active_low = 0, pwm_r, pwm_g, pwm_b and sample_tick are all 0.
- R2: Outside ST_RUN (in ST_IDLE or ST_LOAD), every PWM output equals active_low: 0 when active_low = 0, and 1 when active_low = 1.
- R3: In ST_RUN the period counter steps 0, 1, …, 4094 and then returns to 0, so every channel waveform repeats every 4095 clocks.
- R4: In ST_RUN, a channel is asserted exactly while counter < captured duty. Each period therefore opens with exactly duty asserted cycles, followed by deasserted cycles until the period ends.
- R5: A captured duty of 0 leaves the channel deasserted for the whole period.
- R6: A captured duty of 4095 keeps the channel asserted for the whole period.
- R7: The asserted level is 1 when active_low = 0 and 0 when active_low = 1. Deasserted is the opposite level.
- R8: In ST_RUN, a change on a duty input takes effect only from the first cycle of the next period (counter = 0). The current period finishes with the old value.
- R9: Switching starts only after run_en is set. The first clock edge with run_en high enters ST_LOAD, with outputs still idle. The next edge enters ST_RUN with counter 0. The first edge with run_en low returns the block to ST_IDLE.
- R10: sample_tick is high for exactly one clock in every 25087, regardless of run_en. Counting clock edges since reset release from 1, it is high after edge N when N mod 25087 = 25086.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; 0 holds outputs at the idle level |
| active_low | input | 1 | Polarity: 0 asserted high, 1 asserted low |
| duty_r | input | 12 | Red duty value |
| duty_g | input | 12 | Green duty value |
| duty_b | input | 12 | Blue duty value |
| pwm_r | output | 1 | Red LED driver enable |
| pwm_g | output | 1 | Green LED driver enable |
| pwm_b | output | 1 | Blue LED driver enable |
| sample_tick | output | 1 | One-cycle strobe every 25087 clocks |

## Verification
The compare path is exercised with duty triples that place the three channels in different regimes at the same time: zero, one or two cycles, mid-scale, 4094, and full scale, each under both polarities. These show off-by-one errors at the compare boundary and inverted polarity handling, and confirm that the channels stay independent. A single-cycle duty confirms the 4095-clock period. Changing a duty value mid-period shows whether the shadow update waits for the wrap. Toggling run_en shows the one-cycle load delay and the return to the idle level. The tick is compared against its edge count across three full intervals while the PWM side is being started and stopped.

// File: rtl/rgb_pwm_pkg.sv
package rgb_pwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } pwm_state_e;
endpackage

// File: rtl/pwm_seq_fsm.sv
module pwm_seq_fsm
    import rgb_pwm_pkg::*;
#(
    parameter int PERIOD = 4095,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    output pwm_state_e       st,
    output logic [CNT_W-1:0] cnt,
    output logic             load_o,
    output logic             active_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    pwm_state_e st_nxt;
    logic       wrap;

    assign wrap = (cnt == LAST);

    // next-state decode
    always_comb begin
        unique case (st)
            ST_IDLE: st_nxt = run_en ? ST_LOAD : ST_IDLE;  // start
            ST_LOAD: st_nxt = run_en ? ST_RUN  : ST_IDLE;  // go / stop
            ST_RUN:  st_nxt = run_en ? ST_RUN  : ST_IDLE;  // stop
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // period counter: runs only while staying in ST_RUN
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt <= '0;
        else if (st == ST_RUN && run_en) cnt <= wrap ? '0 : cnt + 1'b1;
        else                             cnt <= '0;
    end

    // state-derived outputs
    always_comb begin
        load_o   = 1'b0;
        active_o = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_LOAD: load_o = 1'b1;
            ST_RUN: begin
                active_o = 1'b1;
                load_o   = wrap && run_en;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
    parameter int DUTY_W = 12,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              active,
    input  logic              pol,
    input  logic [DUTY_W-1:0] duty,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DUTY_W-1:0] shadow,
    output logic              out
);
    localparam int CMP_W = (DUTY_W > CNT_W) ? DUTY_W : CNT_W;

    logic on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    shadow <= '0;
        else if (load) shadow <= duty;
    end

    assign on  = CMP_W'(cnt) < CMP_W'(shadow);
    assign out = active ? (on ^ pol) : pol;
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int DIV = 25087
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int TW = $clog2(DIV);
    localparam logic [TW-1:0] LAST = TW'(DIV - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/rgb_pwm_gen.sv
module rgb_pwm_gen
    import rgb_pwm_pkg::*;
#(
    parameter int DUTY_W     = 12,
    parameter int PERIOD     = 4095,
    parameter int SAMPLE_DIV = 25087
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              active_low,
    input  logic [DUTY_W-1:0] duty_r,
    input  logic [DUTY_W-1:0] duty_g,
    input  logic [DUTY_W-1:0] duty_b,
    output logic              pwm_r,
    output logic              pwm_g,
    output logic              pwm_b,
    output logic              sample_tick
);
    localparam int NCH   = 3;
    localparam int CNT_W = $clog2(PERIOD);

    pwm_state_e                  st;
    logic [CNT_W-1:0]            cnt;
    logic                        load;
    logic                        active;
    logic [NCH-1:0][DUTY_W-1:0]  duty_vec;
    logic [NCH-1:0][DUTY_W-1:0]  shadow_q;
    logic [NCH-1:0]              pwm_vec;

    assign duty_vec = {duty_b, duty_g, duty_r};

    pwm_seq_fsm #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .st       (st),
        .cnt      (cnt),
        .load_o   (load),
        .active_o (active)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_chan #(.DUTY_W(DUTY_W), .CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .active (active),
            .pol    (active_low),
            .duty   (duty_vec[c]),
            .cnt    (cnt),
            .shadow (shadow_q[c]),
            .out    (pwm_vec[c])
        );
    end

    tick_divider #(.DIV(SAMPLE_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sample_tick)
    );

    assign pwm_r = pwm_vec[0];
    assign pwm_g = pwm_vec[1];
    assign pwm_b = pwm_vec[2];
endmodule

// File: rtl/rgb_pwm_gen_chk.sv
module rgb_pwm_gen_chk
    import rgb_pwm_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int DUTY_W = 12,
    parameter int CNT_W  = 12,
    parameter int PERIOD = 4095
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       run_en,
    input logic                       pol,
    input pwm_state_e                 st,
    input logic [CNT_W-1:0]           cnt,
    input logic [NCH-1:0][DUTY_W-1:0] shadow,
    input logic [NCH-1:0]             pwm,
    input logic                       tick
);
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (st != ST_RUN) |-> (pwm == {NCH{pol}})); // R2
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_W'(PERIOD - 1)); // R3
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_RUN && run_en && cnt == CNT_W'(PERIOD - 1)) |=> (cnt == '0)); // R3
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_RUN && cnt != CNT_W'(PERIOD - 1)) |=> $stable(shadow)); // R8
    AST_RUN_EXIT: assert property (@(posedge clk) disable iff (!rst_n) (st != ST_IDLE && !run_en) |=> (st == ST_IDLE)); // R9
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R10

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_RUN && shadow[c] == '0) |-> (pwm[c] == pol)); // R5
        AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_RUN && int'(shadow[c]) >= PERIOD) |-> (pwm[c] != pol)); // R6
    end
endmodule

bind rgb_pwm_gen rgb_pwm_gen_chk #(
    .NCH    (NCH),
    .DUTY_W (DUTY_W),
    .CNT_W  (CNT_W),
    .PERIOD (PERIOD)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .pol    (active_low),
    .st     (st),
    .cnt    (cnt),
    .shadow (shadow_q),
    .pwm    (pwm_vec),
    .tick   (sample_tick)
);

// File: tb/rgb_pwm_gen_test.sv
module rgb_pwm_gen_test;
    localparam int PER  = 4095;
    localparam int SDIV = 25087;

    typedef struct packed {
        logic        pol;
        logic [11:0] dr;
        logic [11:0] dg;
        logic [11:0] db;
        logic [12:0] er;
        logic [12:0] eg;
        logic [12:0] eb;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{1'b0, 12'd0,    12'd1,    12'd2,    13'd0,    13'd1,    13'd2},    // R5 zero and tiny duties
        '{1'b0, 12'd100,  12'd2048, 12'd4094, 13'd100,  13'd2048, 13'd4094},
        '{1'b0, 12'd4095, 12'd4095, 12'd4094, 13'd4095, 13'd4095, 13'd4094}, // R6 full scale
        '{1'b1, 12'd0,    12'd4095, 12'd1000, 13'd0,    13'd4095, 13'd1000}, // R7 inverted
        '{1'b1, 12'd3,    12'd2047, 12'd4000, 13'd3,    13'd2047, 13'd4000}, // R7
        '{1'b0, 12'd1234, 12'd0,    12'd4095, 13'd1234, 13'd0,    13'd4095},
        '{1'b1, 12'd4095, 12'd1,    12'd0,    13'd4095, 13'd1,    13'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        active_low = 1'b0;
    logic [11:0] duty_r = '0;
    logic [11:0] duty_g = '0;
    logic [11:0] duty_b = '0;
    logic        pwm_r, pwm_g, pwm_b, sample_tick;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_n = 0;
    bit mon_on = 1'b1;

    always #10 clk = ~clk;

    rgb_pwm_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .active_low  (active_low),
        .duty_r      (duty_r),
        .duty_g      (duty_g),
        .duty_b      (duty_b),
        .pwm_r       (pwm_r),
        .pwm_g       (pwm_g),
        .pwm_b       (pwm_b),
        .sample_tick (sample_tick)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [2:0] asserted();
        return {pwm_b, pwm_g, pwm_r} ^ {3{active_low}};
    endfunction

    // edges since reset release, for the tick reference (R10)
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_n <= 0;
        else        cyc_n <= cyc_n + 1;
    end

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            bit exp_t;
            exp_t = ((cyc_n % SDIV) == SDIV - 1);
            if (exp_t || sample_tick)
                chk(sample_tick == exp_t, $sformatf("R10 tick at edge %0d", cyc_n), int'(sample_tick), int'(exp_t));
        end
    end

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    // from idle: program, enable, and step to the negedge of the LOAD cycle
    task automatic start_run(input logic pol, input logic [11:0] r, input logic [11:0] g, input logic [11:0] b);
        @(negedge clk);
        run_en = 1'b0; active_low = pol; duty_r = r; duty_g = g; duty_b = b;
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        #15;
        chk({pwm_b, pwm_g, pwm_r, sample_tick} == 4'b0, "R1 in reset", {pwm_b, pwm_g, pwm_r, sample_tick}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({pwm_b, pwm_g, pwm_r, sample_tick} == 4'b0, "R1 after release", {pwm_b, pwm_g, pwm_r, sample_tick}, 0);

        // R2: idle level follows polarity
        active_low = 1'b1;
        @(negedge clk);
        chk({pwm_b, pwm_g, pwm_r} == 3'b111, "R2 idle pol=1", {pwm_b, pwm_g, pwm_r}, 7);
        active_low = 1'b0;
        @(negedge clk);
        chk({pwm_b, pwm_g, pwm_r} == 3'b000, "R2 idle pol=0", {pwm_b, pwm_g, pwm_r}, 0);

        // R9: no switching without enable, one-cycle load, stop
        begin
            int errs = 0;
            duty_r = 12'd4095; duty_g = 12'd4095; duty_b = 12'd4095;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                if ({pwm_b, pwm_g, pwm_r} != 3'b000) errs++;
            end
            chk(errs == 0, "R9 disabled stays idle", errs, 0);
            run_en = 1'b1;
            @(negedge clk);
            chk({pwm_b, pwm_g, pwm_r} == 3'b000, "R9 load cycle idle", {pwm_b, pwm_g, pwm_r}, 0);
            @(negedge clk);
            chk({pwm_b, pwm_g, pwm_r} == 3'b111, "R9 run after load", {pwm_b, pwm_g, pwm_r}, 7);
            run_en = 1'b0;
            @(negedge clk);
            chk({pwm_b, pwm_g, pwm_r} == 3'b000, "R9 stop to idle", {pwm_b, pwm_g, pwm_r}, 0);
        end

        // R4: table of duty triples, one full period each
        for (int v = 0; v < 7; v++) begin
            int on_c [3];
            int shape [3];
            int dv [3];
            int ev [3];
            logic [2:0] a;
            dv = '{int'(TBL[v].dr), int'(TBL[v].dg), int'(TBL[v].db)};
            ev = '{int'(TBL[v].er), int'(TBL[v].eg), int'(TBL[v].eb)};
            on_c = '{0, 0, 0};
            shape = '{0, 0, 0};
            start_run(TBL[v].pol, TBL[v].dr, TBL[v].dg, TBL[v].db);
            for (int i = 0; i < PER; i++) begin
                @(negedge clk);
                a = asserted();
                for (int c = 0; c < 3; c++) begin
                    if (a[c]) on_c[c]++;
                    if (a[c] != (i < dv[c])) shape[c]++;
                end
            end
            for (int c = 0; c < 3; c++)
                chk(on_c[c] == ev[c] && shape[c] == 0,
                    $sformatf("R4 vec %0d ch %0d shape_err=%0d", v, c, shape[c]), on_c[c], ev[c]);
        end

        // R3: single-cycle duty repeats every 4095 clocks
        begin
            int errs = 0;
            int hits = 0;
            start_run(1'b0, 12'd1, 12'd0, 12'd0);
            for (int i = 0; i <= 2 * PER; i++) begin
                @(negedge clk);
                if (pwm_r) hits++;
                if (pwm_r != ((i % PER) == 0)) errs++;
            end
            chk(errs == 0 && hits == 3, "R3 period hits", hits, 3);
        end

        // R8: duty change mid-period waits for the wrap
        begin
            int er = 0;
            int eg = 0;
            start_run(1'b0, 12'd4095, 12'd0, 12'd0);
            for (int i = 0; i < 2 * PER; i++) begin
                @(negedge clk);
                if (pwm_r != (i < PER)) er++;
                if (pwm_g != (i >= PER)) eg++;
                if (i == 10) begin
                    duty_r = 12'd0;
                    duty_g = 12'd4095;
                end
            end
            chk(er == 0, "R8 red old value kept", er, 0);
            chk(eg == 0, "R8 green new value at wrap", eg, 0);
        end

        // let the tick monitor span three intervals (R10)
        while (cyc_n < 3 * SDIV + 10) @(negedge clk);
        mon_on = 1'b0;

        // R1: asynchronous reset while running
        start_run(1'b0, 12'd4095, 12'd4095, 12'd4095);
        @(negedge clk);
        #3 rst_n = 1'b0;
        #1;
        chk({pwm_b, pwm_g, pwm_r, sample_tick} == 4'b0, "R1 async reset", {pwm_b, pwm_g, pwm_r, sample_tick}, 0);
        run_en = 1'b0;
        summary();
    end
endmodule